// File: doc/BRIEF.md
# Serial Receive Buffer with Character Timeout

This block sits between a serial deserializer and the register interface of a 16550-style serial controller. It takes each received byte, or a break event, and either queues it in a 16-entry FIFO or, with the FIFO switched off, holds it in a single holding register. A host read of the data register pops the oldest byte. The block keeps the data-ready, overrun, break and timeout-pending flags up to date. It also reports whether the fill level has reached the trigger level chosen by the host.

A timeout counter runs on a baud-rate tick strobe, one tick per bit period. It is loaded with four character times, and the character time follows from the frame format the host has set. When the counter runs out while bytes are still waiting, the timeout-pending flag is raised. A downstream interrupt encoder uses it to alert the host about a partial FIFO.

A control write sets FIFO enable, the trigger level and two flush requests. Changing the enable bit flushes both directions. The transmit flush request is passed on as a pulse for the transmit side.

Top module: `uart_rx_buffer`

## Requirements
- R1: In FIFO mode a byte that arrives while 16 bytes are stored is dropped and sets `overrun`. The stored bytes stay intact and are read back in arrival order.
- R2: `trig_hit` in FIFO mode is high when `fill_count` is at least the level selected by `ctrl_trig`: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14. In holding-register mode `trig_hit` follows `data_ready`.
- R3: In FIFO mode every arrival and every read that leaves data behind reload the timeout counter with 4 character times. If the counter runs out with data stored, `timeout_pend` rises one cycle after the final tick.
- R4: A data read clears `timeout_pend`. A FIFO read that leaves the FIFO empty also clears `data_ready` and `break_flag`.
- R5: In FIFO mode with an empty FIFO, `rd_data` is 0x00 and a read changes no stored state.
- R6: A receive flush empties the FIFO, clears `data_ready`, `break_flag` and `timeout_pend`, and stops the timeout counter. An arrival in the same cycle is ignored.
- R7: A control write that changes the FIFO-enable bit performs a receive flush and drives `tx_flush` high in that cycle. `tx_flush` is also high for a write with `ctrl_tx_flush` set, and is low otherwise.
- R8: `rx_break` stores a 0x00 byte through the normal arrival path and sets both `break_flag` and `data_ready`.
- R9: In holding-register mode a byte that arrives while `data_ready` is set replaces the held byte and sets `overrun`. A read returns the held byte and clears `data_ready` and `break_flag`.
- R10: One character time is `line_fmt` ticks of frame length. The frame is 1 start bit, plus 5 + `line_fmt[1:0]` data bits, plus 1 parity bit when `line_fmt[3]` is set, plus 2 stop bits when `line_fmt[2]` is set (otherwise 1).
- R11: `lsr_rd` clears `break_flag` and `overrun`. A flag being set in the same cycle takes precedence.
- R12: After reset the FIFO is off and empty, all four flags are low, and `trig_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Deserializer delivers `rx_data` this cycle |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break condition received this cycle (stores 0x00) |
| rd_en | input | 1 | Host reads the data register this cycle |
| rd_data | output | 8 | Data register read value |
| lsr_rd | input | 1 | Host reads the line status register this cycle |
| ctrl_wr | input | 1 | Host writes the FIFO control register this cycle |
| ctrl_fifo_en | input | 1 | FIFO enable value written |
| ctrl_rx_flush | input | 1 | Receive flush request |
| ctrl_tx_flush | input | 1 | Transmit flush request |
| ctrl_trig | input | 2 | Trigger level select |
| line_fmt | input | 4 | Frame format: [1:0] data length code, [2] two stop bits, [3] parity present |
| baud_tick | input | 1 | One pulse per bit period |
| tx_flush | output | 1 | Transmit flush pulse for the transmit side |
| data_ready | output | 1 | Received data available |
| overrun | output | 1 | A byte was lost |
| break_flag | output | 1 | A break was received |
| timeout_pend | output | 1 | Data has waited four character times unread |
| fill_count | output | 5 | Bytes held in the FIFO |
| trig_hit | output | 1 | Fill level reached the trigger level |

## Verification
A corrupted pointer or fill count shows up in `fill_count` on the next clock. It shows up on `rd_data` at the next read as a byte out of order or a stale byte. A flag state machine that misses a set or clear condition is visible on its own output port one cycle after the event. A timeout counter that loads the wrong value, or counts past its end, moves the rise of `timeout_pend` by at least one tick from four character times. A reference model compared on every clock therefore catches it within a single timeout window.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int FRAME_MAX = 12;

  // start + data (5..8) + optional parity + stop (1 or 2)
  function automatic logic [3:0] frame_bits(input logic [3:0] fmt);
    logic [3:0] n;
    n = 4'd6 + {2'b00, fmt[1:0]} + {3'b000, fmt[3]} + (fmt[2] ? 4'd2 : 4'd1);
    return n;
  endfunction

  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    logic [4:0] lv;
    case (sel)
      2'b00:   lv = 5'd1;
      2'b01:   lv = 5'd4;
      2'b10:   lv = 5'd8;
      default: lv = 5'd14;
    endcase
    return lv;
  endfunction
endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr_en,
  input  logic [WIDTH-1:0]           wr_data,
  input  logic                       rd_en,
  output logic [WIDTH-1:0]           head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (wr_en) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + AW'(1);
      if (rd_en) rptr_d = (rptr_q == LAST) ? '0 : rptr_q + AW'(1);
      cnt_d = cnt_q + CW'(wr_en) - CW'(rd_en);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) mem[wptr_q] <= wr_data;
  end

  assign head  = mem[rptr_q];
  assign count = cnt_q;

  // R1: the controller never writes into a full store
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |-> (cnt_q < CW'(DEPTH)));
  // R5: the controller never pops an empty store
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !clr) |-> (cnt_q != '0));
endmodule

// File: rtl/rxbuf_timer.sv
module rxbuf_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          expire
);
  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign expire = armed_q && tick && (cnt_q == CW'(1)) && !load && !clr;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (clr) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (load) begin
      armed_d = 1'b1;
      cnt_d   = load_val;
    end else if (armed_q && tick) begin
      if (cnt_q == CW'(1)) begin
        armed_d = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  // R3: a running counter always has ticks left
  p_armed_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (cnt_q != '0));
  // R3: expiry stops the counter
  p_expire_stops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !armed_q);
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import rxbuf_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TO_CHARS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_valid,
  input  logic [7:0]                 rx_data,
  input  logic                       rx_break,
  input  logic                       rd_en,
  output logic [7:0]                 rd_data,
  input  logic                       lsr_rd,
  input  logic                       ctrl_wr,
  input  logic                       ctrl_fifo_en,
  input  logic                       ctrl_rx_flush,
  input  logic                       ctrl_tx_flush,
  input  logic [1:0]                 ctrl_trig,
  input  logic [3:0]                 line_fmt,
  input  logic                       baud_tick,
  output logic                       tx_flush,
  output logic                       data_ready,
  output logic                       overrun,
  output logic                       break_flag,
  output logic                       timeout_pend,
  output logic [$clog2(DEPTH+1)-1:0] fill_count,
  output logic                       trig_hit
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int TW = $clog2(TO_CHARS*FRAME_MAX+1);

  logic       fen_q, fen_d;
  logic [1:0] trig_q, trig_d;
  logic [7:0] hold_q, hold_d;
  logic       dr_q, dr_d, ovr_q, ovr_d, brk_q, brk_d, tp_q, tp_d;

  logic          toggle, rx_clr, push_in, full, empty;
  logic          f_push, f_pop, ovf, rd_clear, reload, expire;
  logic [7:0]    push_byte, head;
  logic [CW-1:0] count, count_after;
  logic [TW-1:0] to_load;

  assign toggle    = ctrl_wr && (ctrl_fifo_en != fen_q);
  assign rx_clr    = ctrl_wr && (ctrl_rx_flush || toggle);
  assign tx_flush  = ctrl_wr && (ctrl_tx_flush || toggle);
  assign push_in   = rx_valid || rx_break;
  assign push_byte = rx_break ? 8'h00 : rx_data;
  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);

  assign f_push      = fen_q && push_in && !full && !rx_clr;
  assign f_pop       = fen_q && rd_en && !empty && !rx_clr;
  assign count_after = count + CW'(f_push) - CW'(f_pop);
  assign ovf         = push_in && !rx_clr && (fen_q ? full : dr_q);
  assign rd_clear    = rd_en && !rx_clr && (fen_q ? (count_after == '0) : 1'b1);
  assign reload      = fen_q && !rx_clr && (push_in || (f_pop && count_after != '0));
  assign to_load     = TW'(TO_CHARS) * TW'(frame_bits(line_fmt));

  rxbuf_store #(.WIDTH(8), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .wr_en(f_push), .wr_data(push_byte),
    .rd_en(f_pop), .head(head), .count(count)
  );

  rxbuf_timer #(.CW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .load(reload), .load_val(to_load),
    .tick(baud_tick), .expire(expire)
  );

  always_comb begin
    fen_d  = ctrl_wr ? ctrl_fifo_en : fen_q;
    trig_d = ctrl_wr ? ctrl_trig : trig_q;
    hold_d = (!fen_q && push_in && !rx_clr) ? push_byte : hold_q;

    if (rx_clr)        dr_d = 1'b0;
    else if (push_in)  dr_d = 1'b1;
    else if (rd_clear) dr_d = 1'b0;
    else               dr_d = dr_q;

    if (rx_clr)                  brk_d = 1'b0;
    else if (rx_break)           brk_d = 1'b1;
    else if (rd_clear || lsr_rd) brk_d = 1'b0;
    else                         brk_d = brk_q;

    if (ovf)         ovr_d = 1'b1;
    else if (lsr_rd) ovr_d = 1'b0;
    else             ovr_d = ovr_q;

    if (rx_clr || rd_en)      tp_d = 1'b0;
    else if (expire && !empty) tp_d = 1'b1;
    else                      tp_d = tp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fen_q  <= 1'b0;
      trig_q <= 2'b00;
      hold_q <= 8'h00;
      dr_q   <= 1'b0;
      ovr_q  <= 1'b0;
      brk_q  <= 1'b0;
      tp_q   <= 1'b0;
    end else begin
      fen_q  <= fen_d;
      trig_q <= trig_d;
      hold_q <= hold_d;
      dr_q   <= dr_d;
      ovr_q  <= ovr_d;
      brk_q  <= brk_d;
      tp_q   <= tp_d;
    end
  end

  assign rd_data      = fen_q ? (empty ? 8'h00 : head) : hold_q;
  assign data_ready   = dr_q;
  assign overrun      = ovr_q;
  assign break_flag   = brk_q;
  assign timeout_pend = tp_q;
  assign fill_count   = count;
  assign trig_hit     = fen_q ? (count >= CW'(trig_level(trig_q))) : dr_q;

  // R1: a byte arriving at a full FIFO is lost, contents kept
  p_full_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fen_q && full && push_in && !rx_clr && !rd_en) |=> (overrun && fill_count == CW'(DEPTH)));
  // R3: the timeout flag only rises while data is held
  p_pend_has_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_pend) |-> (fill_count != '0));
  // R4: any data read drops the timeout flag
  p_read_drops_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !timeout_pend);
  // R6: flush leaves an empty, quiet receiver
  p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (fill_count == '0 && !data_ready && !break_flag && !timeout_pend));
  // R7: toggling the enable bit empties the FIFO
  p_toggle_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    toggle |=> (fill_count == '0));
  // R8: a break marks both status flags
  p_break_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_break && !rx_clr) |=> (break_flag && data_ready));
  // R9: holding-register overrun
  p_hold_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fen_q && data_ready && push_in && !rx_clr) |=> overrun);
endmodule

// File: tb/tb_uart_rx_buffer.sv
module tb_uart_rx_buffer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 0, rx_break = 0, rd_en = 0, lsr_rd = 0, ctrl_wr = 0;
  logic ctrl_fifo_en = 0, ctrl_rx_flush = 0, ctrl_tx_flush = 0, baud_tick = 0;
  logic [7:0] rx_data = 0;
  logic [1:0] ctrl_trig = 0;
  logic [3:0] line_fmt = 4'b0011;
  logic [7:0] rd_data;
  logic tx_flush, data_ready, overrun, break_flag, timeout_pend, trig_hit;
  logic [4:0] fill_count;

  int checks = 0, fails = 0;
  string phase = "R12";

  uart_rx_buffer dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
    .rd_en(rd_en), .rd_data(rd_data), .lsr_rd(lsr_rd), .ctrl_wr(ctrl_wr),
    .ctrl_fifo_en(ctrl_fifo_en), .ctrl_rx_flush(ctrl_rx_flush), .ctrl_tx_flush(ctrl_tx_flush),
    .ctrl_trig(ctrl_trig), .line_fmt(line_fmt), .baud_tick(baud_tick), .tx_flush(tx_flush),
    .data_ready(data_ready), .overrun(overrun), .break_flag(break_flag),
    .timeout_pend(timeout_pend), .fill_count(fill_count), .trig_hit(trig_hit)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0] q[$];
  bit m_fen, m_dr, m_ovr, m_brk, m_pend, m_armed;
  int m_trig, m_left;
  logic [7:0] m_hold;

  function automatic int lvl(input int s);
    case (s) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
  endfunction

  function automatic int frame_len(input logic [3:0] f);
    return 1 + 5 + int'(f[1:0]) + int'(f[3]) + (f[2] ? 2 : 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_fen = 0; m_dr = 0; m_ovr = 0; m_brk = 0; m_pend = 0;
      m_armed = 0; m_left = 0; m_trig = 0; m_hold = 0;
    end else begin
      bit tog, clr, push, popd, ovf, rdclr, reload, expire;
      int n, left;
      logic [7:0] b;
      tog  = ctrl_wr && (ctrl_fifo_en != m_fen);
      clr  = ctrl_wr && (ctrl_rx_flush || tog);
      push = rx_valid || rx_break;
      b    = rx_break ? 8'h00 : rx_data;
      n    = q.size();
      if (clr) begin
        q.delete(); m_dr = 0; m_brk = 0; m_pend = 0; m_armed = 0;
        if (lsr_rd) m_ovr = 0;
      end else begin
        popd = 0; ovf = 0; reload = 0;
        if (m_fen) begin
          if (rd_en && n > 0) begin void'(q.pop_front()); popd = 1; end
          if (push) begin
            if (n == 16) ovf = 1; else q.push_back(b);
          end
          left   = q.size();
          reload = push || (popd && left != 0);
          rdclr  = rd_en && left == 0;
        end else begin
          ovf = push && m_dr;
          if (push) m_hold = b;
          rdclr = rd_en;
        end
        expire = m_armed && baud_tick && m_left == 1 && !reload;
        if (push) m_dr = 1; else if (rdclr) m_dr = 0;
        if (rx_break) m_brk = 1; else if (rdclr || lsr_rd) m_brk = 0;
        if (ovf) m_ovr = 1; else if (lsr_rd) m_ovr = 0;
        if (rd_en) m_pend = 0; else if (expire && n > 0) m_pend = 1;
        if (reload) begin m_armed = 1; m_left = 4 * frame_len(line_fmt); end
        else if (m_armed && baud_tick) begin
          if (m_left == 1) m_armed = 0; else m_left--;
        end
      end
      if (ctrl_wr) begin m_fen = ctrl_fifo_en; m_trig = int'(ctrl_trig); end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int exp_rd, exp_th;
      exp_rd = m_fen ? (q.size() > 0 ? int'(q[0]) : 0) : int'(m_hold);
      exp_th = m_fen ? int'(q.size() >= lvl(m_trig)) : int'(m_dr);
      chk({phase, " model data_ready"}, data_ready, m_dr);
      chk({phase, " model overrun"}, overrun, m_ovr);
      chk({phase, " model break_flag"}, break_flag, m_brk);
      chk({phase, " model timeout_pend"}, timeout_pend, m_pend);
      chk({phase, " model fill_count"}, fill_count, q.size());
      chk({phase, " model trig_hit"}, trig_hit, exp_th);
      chk({phase, " model rd_data"}, rd_data, exp_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic push(input logic [7:0] v);
    rx_valid = 1; rx_data = v; step(); rx_valid = 0;
  endtask

  task automatic push_break();
    rx_break = 1; step(); rx_break = 0;
  endtask

  task automatic do_read(output logic [7:0] v);
    rd_en = 1; #1 v = rd_data; step(); rd_en = 0;
  endtask

  task automatic ctrl(input bit fen, input bit rxf, input bit txf, input logic [1:0] tr,
                      output bit txo);
    ctrl_wr = 1; ctrl_fifo_en = fen; ctrl_rx_flush = rxf; ctrl_tx_flush = txf; ctrl_trig = tr;
    #1 txo = tx_flush;
    step();
    ctrl_wr = 0; ctrl_rx_flush = 0; ctrl_tx_flush = 0;
  endtask

  task automatic lsr();
    lsr_rd = 1; step(); lsr_rd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    bit txo;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 data_ready", data_ready, 0);
    chk("R12 overrun", overrun, 0);
    chk("R12 fill_count", fill_count, 0);
    chk("R12 trig_hit", trig_hit, 0);
    chk("R12 timeout_pend", timeout_pend, 0);

    // R9 holding-register mode
    phase = "R9";
    push(8'h41);
    chk("R9 trig_hit follows data_ready", trig_hit, 1);
    push(8'h42);
    chk("R9 overrun on replace", overrun, 1);
    do_read(v);
    chk("R9 newest byte held", v, 8'h42);
    chk("R9 data_ready cleared by read", data_ready, 0);
    phase = "R11";
    lsr();
    chk("R11 overrun cleared by status read", overrun, 0);

    // R7 enable toggle, R2 trigger levels
    phase = "R7";
    ctrl(1, 0, 0, 2'b01, txo);
    chk("R7 toggle forces tx flush", txo, 1);
    phase = "R2";
    for (int i = 0; i < 3; i++) push(8'h10 + 8'(i));
    chk("R2 below level 4", trig_hit, 0);
    push(8'h13);
    chk("R2 at level 4", trig_hit, 1);
    ctrl(1, 0, 0, 2'b10, txo);
    chk("R7 no tx flush without request", txo, 0);
    chk("R2 below level 8", trig_hit, 0);
    for (int i = 4; i < 8; i++) push(8'h10 + 8'(i));
    chk("R2 at level 8", trig_hit, 1);
    ctrl(1, 0, 0, 2'b11, txo);
    for (int i = 8; i < 13; i++) push(8'h10 + 8'(i));
    chk("R2 below level 14", trig_hit, 0);
    push(8'h1D);
    chk("R2 at level 14", trig_hit, 1);

    // R1 overflow keeps contents
    phase = "R1";
    push(8'h1E); push(8'h1F);
    chk("R1 full", fill_count, 16);
    push(8'hEE);
    chk("R1 overrun", overrun, 1);
    chk("R1 count held", fill_count, 16);
    for (int i = 0; i < 16; i++) begin
      do_read(v);
      chk("R1 order", v, 8'h10 + i);
    end
    phase = "R4";
    chk("R4 drain clears data_ready", data_ready, 0);
    phase = "R5";
    do_read(v);
    chk("R5 empty read value", v, 0);
    chk("R5 empty read count", fill_count, 0);
    lsr();

    // R8 break
    phase = "R8";
    ctrl(1, 0, 0, 2'b00, txo);
    push_break();
    chk("R8 break_flag", break_flag, 1);
    chk("R8 data_ready", data_ready, 1);
    chk("R2 level 1", trig_hit, 1);
    do_read(v);
    chk("R8 null byte", v, 0);
    chk("R4 break cleared on drain", break_flag, 0);

    // R3 / R10 timeout: 8 data, 1 stop, no parity = 10 bits -> 40 ticks
    phase = "R3";
    line_fmt = 4'b0011;
    push(8'h55);
    baud_tick = 1;
    repeat (39) step();
    chk("R10 no timeout before 40 ticks", timeout_pend, 0);
    step();
    chk("R3 timeout after 40 ticks", timeout_pend, 1);
    baud_tick = 0;
    do_read(v);
    chk("R4 read clears timeout", timeout_pend, 0);

    // R3 reload on a read that leaves data; 5 data, parity, 2 stop = 9 bits -> 36 ticks
    phase = "R10";
    line_fmt = 4'b1100;
    push(8'h61); push(8'h62);
    baud_tick = 1;
    repeat (20) step();
    do_read(v);
    chk("R3 first byte", v, 8'h61);
    repeat (35) step();
    chk("R10 reload after read, 35 ticks", timeout_pend, 0);
    step();
    chk("R10 timeout after 36 ticks", timeout_pend, 1);
    baud_tick = 0;
    do_read(v);
    chk("R4 emptying read drops data_ready", data_ready, 0);

    // R6 flush, R7 toggle with data
    phase = "R6";
    push(8'h71); push(8'h72); push(8'h73);
    ctrl(1, 1, 0, 2'b00, txo);
    chk("R6 flush empties", fill_count, 0);
    chk("R6 flush clears data_ready", data_ready, 0);
    chk("R7 rx flush alone no tx flush", txo, 0);
    phase = "R7";
    push(8'h81); push_break();
    ctrl(0, 0, 0, 2'b00, txo);
    chk("R7 toggle off tx flush", txo, 1);
    chk("R7 toggle empties", fill_count, 0);
    chk("R7 toggle clears break", break_flag, 0);
    ctrl(0, 0, 1, 2'b00, txo);
    chk("R7 tx flush request", txo, 1);
    repeat (2) step();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule